// File: doc/BRIEF.md
# Store-Miss Bus Request Sequencer

This block sits between a processor's cache controller and its system interface. When a store misses in every cache level, the controller hands it the attributes of the miss. These are the coherency attribute of the page, whether a secondary cache is fitted, whether the victim line is dirty, and a configuration bit that disables potential updates. From these the block decides which system-bus requests the miss needs, and then issues them one at a time on a request channel with a valid/ready handshake.

Some requests belong to a cluster, which the bus keeps together. Every request in a cluster except the last carries a cluster flag. A read that is followed by a write of the victim within the same cluster also carries a "write follows" flag. For update pages with potential updates disabled, the block waits after its requests for the read response. It issues a separate update request only when that response is marked shared or dirty-shared. A combination that cannot occur (a coherent attribute without a secondary cache) is reported as an error and produces no requests.

Top module: `smq_top`

## Requirements
- R1: Noncoherent page (attr code 0), no secondary cache, clean victim: a single noncoherent read (kind 0), with cluster=0 and wfwd=0.
- R2: Noncoherent page, no secondary cache, dirty victim: a noncoherent read (kind 0) and then a block write (kind 3), both with cluster=0 and wfwd=0.
- R3: Noncoherent page with a secondary cache: a clean victim gives one kind-0 read. A dirty victim gives a kind-0 read with cluster=1 and wfwd=1, then a kind-3 write with cluster=0.
- R4: Exclusive (attr 1) or shareable (attr 2) page with a secondary cache: one exclusive read (kind 2). A dirty victim turns this into a kind-2 read with cluster=1 and wfwd=1, followed by a kind-3 write with cluster=0.
- R5: Update page (attr 3) with potential updates enabled (pu_dis=0): a coherent read (kind 1, cluster=1) and then a potential update (kind 4). A dirty victim gives the potential update cluster=1 and appends a kind-3 write with cluster=0. wfwd stays 0 throughout.
- R6: Update page with pu_dis=1: a coherent read (kind 1). A dirty victim makes it a cluster of a kind-1 read (cluster=1, wfwd=1) and a kind-3 write. The block then waits for a read response and issues an update (kind 5, cluster=0) only if resp_shared or resp_dshared is set. Otherwise it finishes with no update.
- R7: A read response that arrives outside the wait state of R6 is ignored.
- R8: A coherent attribute (1, 2 or 3) without a secondary cache makes err high for exactly one cycle, on the cycle after the miss is taken, and no request is issued.
- R9: A request stays valid, with kind and flags unchanged, until req_ready accepts it.
- R10: done is high for one cycle, on the cycle after the last request is accepted (or after a response that calls for no update). miss_ready is high only when idle, and miss_valid is ignored while busy.
- R11: After reset: req_valid=0, done=0, err=0, miss_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A store miss is offered |
| miss_ready | output | 1 | Block is idle and takes a miss |
| miss_attr | input | 2 | 0 noncoherent, 1 exclusive, 2 shareable, 3 update |
| miss_has_l2 | input | 1 | Secondary cache present |
| miss_dirty | input | 1 | Victim line is dirty |
| cfg_pu_dis | input | 1 | Potential updates disabled |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request accepted |
| req_kind | output | 3 | 0 nc read, 1 coherent read, 2 exclusive read, 3 write, 4 potential update, 5 update |
| req_cluster | output | 1 | More requests follow in this cluster |
| req_wfwd | output | 1 | Read whose write follows in the cluster |
| resp_valid | input | 1 | Read response arrives |
| resp_shared | input | 1 | Response is shared |
| resp_dshared | input | 1 | Response is dirty-shared |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Not-applicable combination pulse |

## Verification
The hardest case to reach is the conditional update. The block must sit in its wait state, ignore responses that arrived earlier, and then choose between issuing an update and finishing. The stimulus deliberately pulses a shared response while requests are still going out, holds req_ready low on alternate cycles so the wait is entered late, and then gives the real response with each of its flag combinations. Misses offered while busy, including ones that would be illegal, check that nothing leaks into an active sequence.

// File: rtl/smq_pkg.sv
package smq_pkg;
  localparam int MAX_REQ = 3;
  localparam int KIND_W  = 3;
  localparam int ATTR_W  = 2;
  localparam int CNT_W   = $clog2(MAX_REQ + 1);

  typedef enum logic [ATTR_W-1:0] {
    ATTR_NONCOH = 2'd0,
    ATTR_EXCL   = 2'd1,
    ATTR_SHARE  = 2'd2,
    ATTR_UPDATE = 2'd3
  } attr_e;

  typedef enum logic [KIND_W-1:0] {
    K_NC_RD   = 3'd0,
    K_COH_RD  = 3'd1,
    K_EX_RD   = 3'd2,
    K_WRITE   = 3'd3,
    K_POT_UPD = 3'd4,
    K_UPDATE  = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_UPD   = 2'd3
  } state_e;
endpackage

// File: rtl/smq_plan.sv
module smq_plan
  import smq_pkg::*;
(
  input  logic [ATTR_W-1:0]              attr_i,
  input  logic                           has_l2_i,
  input  logic                           dirty_i,
  input  logic                           pu_dis_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [MAX_REQ-1:0][KIND_W-1:0] kinds_o,
  output logic [MAX_REQ-1:0]             wf_o,
  output logic                           clustered_o,
  output logic                           cond_upd_o,
  output logic                           illegal_o
);
  always_comb begin
    cnt_o       = CNT_W'(1);
    kinds_o     = '0;
    wf_o        = '0;
    clustered_o = 1'b0;
    cond_upd_o  = 1'b0;
    illegal_o   = 1'b0;
    case (attr_e'(attr_i))
      ATTR_NONCOH: begin
        kinds_o[0] = K_NC_RD;
        if (dirty_i) begin
          cnt_o       = CNT_W'(2);
          kinds_o[1]  = K_WRITE;
          wf_o[0]     = has_l2_i;
          clustered_o = has_l2_i;
        end
      end
      ATTR_EXCL, ATTR_SHARE: begin
        illegal_o  = !has_l2_i;
        kinds_o[0] = K_EX_RD;
        if (dirty_i) begin
          cnt_o       = CNT_W'(2);
          kinds_o[1]  = K_WRITE;
          wf_o[0]     = 1'b1;
          clustered_o = 1'b1;
        end
      end
      default: begin
        illegal_o  = !has_l2_i;
        kinds_o[0] = K_COH_RD;
        if (pu_dis_i) begin
          cond_upd_o = 1'b1;
          if (dirty_i) begin
            cnt_o       = CNT_W'(2);
            kinds_o[1]  = K_WRITE;
            wf_o[0]     = 1'b1;
            clustered_o = 1'b1;
          end
        end else begin
          clustered_o = 1'b1;
          cnt_o       = CNT_W'(2);
          kinds_o[1]  = K_POT_UPD;
          if (dirty_i) begin
            cnt_o      = CNT_W'(3);
            kinds_o[2] = K_WRITE;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/smq_issue.sv
module smq_issue
  import smq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_ni,
  input  logic                           start_i,
  output logic                           idle_o,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [MAX_REQ-1:0][KIND_W-1:0] kinds_i,
  input  logic [MAX_REQ-1:0]             wf_i,
  input  logic                           clustered_i,
  input  logic                           cond_upd_i,
  input  logic                           illegal_i,
  output logic                           req_valid_o,
  input  logic                           req_ready_i,
  output logic [KIND_W-1:0]              req_kind_o,
  output logic                           req_cluster_o,
  output logic                           req_wfwd_o,
  input  logic                           resp_valid_i,
  input  logic                           resp_shared_i,
  output logic                           done_o,
  output logic                           err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  state_e                         state_q, state_d;
  logic [CNT_W-1:0]               idx_q, idx_d, cnt_q;
  logic [MAX_REQ-1:0][KIND_W-1:0] kinds_q;
  logic [MAX_REQ-1:0]             wf_q;
  logic                           clus_q, cond_q;
  logic                           done_q, done_d, err_q, err_d;
  logic                           load, adv, last;

  assign last = (idx_q == cnt_q - ONE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    load    = 1'b0;
    adv     = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        if (illegal_i) err_d = 1'b1;
        else begin
          load    = 1'b1;
          adv     = 1'b1;
          idx_d   = '0;
          state_d = S_ISSUE;
        end
      end
      S_ISSUE: if (req_ready_i) begin
        adv = 1'b1;
        if (last) begin
          idx_d = '0;
          if (cond_q) state_d = S_WAIT;
          else begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end
        end else idx_d = idx_q + ONE;
      end
      S_WAIT: if (resp_valid_i) begin
        if (resp_shared_i) state_d = S_UPD;
        else begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: if (req_ready_i) begin
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      kinds_q <= '0;
      wf_q    <= '0;
      clus_q  <= 1'b0;
      cond_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (adv) idx_q <= idx_d;
      if (load) begin
        cnt_q   <= cnt_i;
        kinds_q <= kinds_i;
        wf_q    <= wf_i;
        clus_q  <= clustered_i;
        cond_q  <= cond_upd_i;
      end
    end
  end

  assign idle_o        = (state_q == S_IDLE);
  assign req_valid_o   = (state_q == S_ISSUE) || (state_q == S_UPD);
  assign req_kind_o    = (state_q == S_UPD) ? K_UPDATE : kinds_q[idx_q];
  assign req_cluster_o = (state_q == S_ISSUE) && clus_q && !last;
  assign req_wfwd_o    = (state_q == S_ISSUE) && wf_q[idx_q];
  assign done_o        = done_q;
  assign err_o         = err_q;

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_kind_o)
      && $stable(req_cluster_o) && $stable(req_wfwd_o)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o || err_o) |-> idle_o);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    err_o |-> (!req_valid_o && !done_o));
  a_r6_wait_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> !req_valid_o);
  a_r3_wfwd_in_cluster: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_o && req_wfwd_o) |-> req_cluster_o);
endmodule

// File: rtl/smq_top.sv
module smq_top
  import smq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ATTR_W-1:0] miss_attr,
  input  logic              miss_has_l2,
  input  logic              miss_dirty,
  input  logic              cfg_pu_dis,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [KIND_W-1:0] req_kind,
  output logic              req_cluster,
  output logic              req_wfwd,
  input  logic              resp_valid,
  input  logic              resp_shared,
  input  logic              resp_dshared,
  output logic              done,
  output logic              err
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [CNT_W-1:0]               p_cnt;
  logic [MAX_REQ-1:0][KIND_W-1:0] p_kinds;
  logic [MAX_REQ-1:0]             p_wf;
  logic                           p_clus, p_cond, p_illegal, idle;

  smq_plan u_plan (
    .attr_i      (miss_attr),
    .has_l2_i    (miss_has_l2),
    .dirty_i     (miss_dirty),
    .pu_dis_i    (cfg_pu_dis),
    .cnt_o       (p_cnt),
    .kinds_o     (p_kinds),
    .wf_o        (p_wf),
    .clustered_o (p_clus),
    .cond_upd_o  (p_cond),
    .illegal_o   (p_illegal)
  );

  smq_issue u_issue (
    .clk           (clk),
    .rst_ni        (rst_ns),
    .start_i       (miss_valid),
    .idle_o        (idle),
    .cnt_i         (p_cnt),
    .kinds_i       (p_kinds),
    .wf_i          (p_wf),
    .clustered_i   (p_clus),
    .cond_upd_i    (p_cond),
    .illegal_i     (p_illegal),
    .req_valid_o   (req_valid),
    .req_ready_i   (req_ready),
    .req_kind_o    (req_kind),
    .req_cluster_o (req_cluster),
    .req_wfwd_o    (req_wfwd),
    .resp_valid_i  (resp_valid),
    .resp_shared_i (resp_shared || resp_dshared),
    .done_o        (done),
    .err_o         (err)
  );

  assign miss_ready = idle;

  a_r11_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |-> !miss_ready);
endmodule

// File: tb/tb_smq_top.sv
module tb_smq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_valid = 1'b0, miss_has_l2 = 1'b0, miss_dirty = 1'b0, cfg_pu_dis = 1'b0;
  logic [1:0] miss_attr = 2'd0;
  logic       req_ready = 1'b1, resp_valid = 1'b0, resp_shared = 1'b0, resp_dshared = 1'b0;
  logic       miss_ready, req_valid, req_cluster, req_wfwd, done, err;
  logic [2:0] req_kind;

  always #2 clk = ~clk;

  smq_top dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_attr(miss_attr), .miss_has_l2(miss_has_l2), .miss_dirty(miss_dirty),
    .cfg_pu_dis(cfg_pu_dis), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cluster(req_cluster), .req_wfwd(req_wfwd),
    .resp_valid(resp_valid), .resp_shared(resp_shared), .resp_dshared(resp_dshared),
    .done(done), .err(err)
  );

  typedef struct packed { logic [2:0] k; logic cl; logic wf; } ereq_t;
  ereq_t q[$];
  int    m_state = 0;
  bit    m_cond = 0, m_done = 0, m_err = 0, model_on = 0, slow = 0;
  int    n_checks = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R11";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // expected sequence taken from the requirements
  task automatic build(input int a, input bit l2, input bit d, input bit pd);
    q.delete();
    m_cond = 0;
    if (a == 0) begin
      if (d) begin q.push_back({3'd0, l2, l2}); q.push_back({3'd3, 1'b0, 1'b0}); end
      else q.push_back({3'd0, 1'b0, 1'b0});
    end else if (a == 1 || a == 2) begin
      if (d) begin q.push_back({3'd2, 1'b1, 1'b1}); q.push_back({3'd3, 1'b0, 1'b0}); end
      else q.push_back({3'd2, 1'b0, 1'b0});
    end else if (pd) begin
      m_cond = 1;
      if (d) begin q.push_back({3'd1, 1'b1, 1'b1}); q.push_back({3'd3, 1'b0, 1'b0}); end
      else q.push_back({3'd1, 1'b0, 1'b0});
    end else begin
      q.push_back({3'd1, 1'b1, 1'b0});
      q.push_back({3'd4, d, 1'b0});
      if (d) q.push_back({3'd3, 1'b0, 1'b0});
    end
  endtask

  always @(negedge clk) if (model_on) begin
    bit    ev;
    ereq_t e;
    ev = (m_state == 1) || (m_state == 3);
    e  = (m_state == 1) ? q[0] : {3'd5, 1'b0, 1'b0};
    chk(miss_ready == (m_state == 0), "R10", "miss_ready", miss_ready, m_state == 0);
    chk(done == m_done, "R10", "done", done, m_done);
    chk(err == m_err, "R8", "err", err, m_err);
    chk(req_valid == ev, {cur_tag, "/R9"}, "req_valid", req_valid, ev);
    if (ev) begin
      chk(req_kind == e.k, {cur_tag, "/R9"}, "req_kind", req_kind, e.k);
      chk(req_cluster == e.cl, {cur_tag, "/R9"}, "req_cluster", req_cluster, e.cl);
      chk(req_wfwd == e.wf, {cur_tag, "/R9"}, "req_wfwd", req_wfwd, e.wf);
    end
    m_done = 0; m_err = 0;
    case (m_state)
      0: if (miss_valid) begin
        if (miss_attr != 0 && !miss_has_l2) m_err = 1;
        else begin build(miss_attr, miss_has_l2, miss_dirty, cfg_pu_dis); m_state = 1; end
      end
      1: if (req_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          if (m_cond) m_state = 2;
          else begin m_done = 1; m_state = 0; end
        end
      end
      2: if (resp_valid) begin
        if (resp_shared || resp_dshared) m_state = 3;
        else begin m_done = 1; m_state = 0; end
      end
      default: if (req_ready) begin m_done = 1; m_state = 0; end
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    #1 req_ready = slow ? cyc[0] : 1'b1;
  end

  always @(posedge clk) if (cyc > 100000) begin
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    finish_up();
  end

  task automatic run_miss(input int a, input bit l2, input bit d, input bit pd, input string tag,
                          input bit sh, input bit dsh, input bit early, input bit poke);
    @(posedge clk); #1;
    cur_tag = tag;
    miss_valid = 1; miss_attr = 2'(a); miss_has_l2 = l2; miss_dirty = d; cfg_pu_dis = pd;
    @(posedge clk); #1;
    miss_valid = 0;
    for (int i = 0; i < 60; i++) begin
      if (m_state == 0) break;
      if (poke && m_state == 1) begin
        // R10: busy start with an illegal combination must be ignored
        miss_valid = 1; miss_attr = 2'd1; miss_has_l2 = 0;
      end else miss_valid = 0;
      if (early && m_state == 1) begin
        // R7: response during issue is ignored
        resp_valid = 1; resp_shared = 1; resp_dshared = 1;
      end else if (m_state == 2) begin
        resp_valid = 1; resp_shared = sh; resp_dshared = dsh;
      end else begin
        resp_valid = 0; resp_shared = 0; resp_dshared = 0;
      end
      @(posedge clk); #1;
    end
    miss_valid = 0; resp_valid = 0; resp_shared = 0; resp_dshared = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_valid == 0, "R11", "req_valid", req_valid, 0);
    chk(done == 0, "R11", "done", done, 0);
    chk(err == 0, "R11", "err", err, 0);
    chk(miss_ready == 1, "R11", "miss_ready", miss_ready, 1);
    model_on = 1;
    for (int s = 0; s < 2; s++) begin
      slow = (s == 1);
      run_miss(0, 0, 0, 0, "R1", 0, 0, 0, 0);
      run_miss(0, 0, 1, 1, "R2", 0, 0, 0, 0);
      run_miss(0, 1, 0, 0, "R3", 0, 0, 0, 0);
      run_miss(0, 1, 1, 0, "R3", 0, 0, 0, 1);
      run_miss(1, 1, 0, 0, "R4", 0, 0, 0, 0);
      run_miss(2, 1, 1, 0, "R4", 0, 0, 0, 0);
      run_miss(1, 1, 1, 1, "R4", 0, 0, 0, 1);
      run_miss(3, 1, 0, 0, "R5", 0, 0, 0, 0);
      run_miss(3, 1, 1, 0, "R5", 0, 0, 0, 1);
      run_miss(3, 1, 0, 1, "R6", 1, 0, 0, 0);
      run_miss(3, 1, 0, 1, "R6", 0, 1, 0, 0);
      run_miss(3, 1, 1, 1, "R6", 0, 0, 0, 0);
      run_miss(3, 1, 1, 1, "R6", 1, 1, 0, 0);
      run_miss(3, 1, 1, 1, "R7", 0, 0, 1, 0);
      run_miss(3, 1, 0, 1, "R7", 0, 0, 1, 1);
      run_miss(1, 0, 0, 0, "R8", 0, 0, 0, 0);
      run_miss(2, 0, 1, 0, "R8", 0, 0, 0, 0);
      run_miss(3, 0, 1, 1, "R8", 0, 0, 0, 0);
    end
    model_on = 0;
    finish_up();
  end
endmodule